// File: doc/BRIEF.md
# Wavefront-Skipping Mask Scheduler

This controller sequences the wavefronts of a masked vector operation on a variable-length SIMD engine. A vector is cut into wavefronts, each as wide as all ALU lanes together. The engine works through one wavefront per cycle. Before a run of masked instructions, an analysis pass streams the mask in, one wavefront per beat. For each wavefront the scheduler records a single flag that says whether any element in it is still enabled.

Every later masked instruction starts an issue pass. The pass emits, in ascending order and one per cycle, only the indices of wavefronts whose flag is set. Wavefronts that are fully masked take no cycle. The recorded summary stays in place for as many instructions as needed, for example through all features of one classifier stage, until a new analysis replaces it.

The controller has three states. In IDLE it waits for a request. ANALYSE consumes mask beats. ISSUE emits indices. There are five transitions:
- IDLE to ANALYSE when an analysis request arrives with a non-zero length.
- IDLE to IDLE when an analysis request arrives with length zero. The flags are cleared and no beats are taken.
- IDLE to ISSUE on an issue request. An analysis request arriving in the same cycle takes precedence.
- ANALYSE to IDLE when the last wavefront's beat is accepted.
- ISSUE to IDLE in the done cycle, once no further non-empty wavefront remains.

Top module: `wf_skip_sched`

## Requirements
- R1: After reset the block is in IDLE. `ana_active`, `wf_valid` and `sched_done` are low and every flag is clear, so an issue request made before any analysis yields `sched_done` with no index.
- R2: An `ana_req` seen in IDLE with a non-zero `ana_len` raises `ana_active` from the next cycle. The block then takes exactly ceil(len/LANES) mask beats, counting only cycles with `mask_valid` high. `ana_active` falls in the cycle after the last beat.
- R3: Beat k describes wavefront k. Bit i of `mask_bits` is element k*LANES+i, with 1 meaning active. The flag of wavefront k is set exactly when at least one counted bit is 1.
- R4: When len is not a multiple of LANES, the last wavefront is partial. Only its lanes below len mod LANES are counted; the other bits are treated as masked.
- R5: Accepting a new analysis clears every flag recorded before. A wavefront that is absent from the new mask is never issued.
- R6: An `iss_req` seen in IDLE starts issue. From the next cycle, `wf_valid` is high for consecutive cycles, with `wf_idx` giving the indices of the non-empty wavefronts in strictly ascending order. Empty wavefronts take no cycle.
- R7: In the cycle after the last index, `sched_done` is high for exactly one cycle with `wf_valid` low. The block is then in IDLE again.
- R8: When no wavefront is non-empty, `sched_done` is high in the first cycle after `iss_req` and no index is emitted.
- R9: The flag summary is kept across issue passes. Repeated `iss_req` without a new analysis give the same index sequence.
- R10: An `ana_req` during ISSUE is refused and leaves the flags unchanged. An `iss_req` during ANALYSE is ignored.
- R11: An `ana_len` of zero takes no beats and leaves all flags clear. A length above MAX_WF*LANES is clamped to MAX_WF full wavefronts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ana_req | input | 1 | Request a new mask analysis |
| ana_len | input | LEN_W | Vector length in elements for the analysis |
| mask_valid | input | 1 | Mask beat present |
| mask_bits | input | LANES | Mask of one wavefront, bit i = lane i |
| ana_active | output | 1 | Analysis pass in progress, beats are being taken |
| iss_req | input | 1 | Start issuing the current schedule |
| wf_valid | output | 1 | `wf_idx` holds a wavefront to execute |
| wf_idx | output | IDX_W | Index of the wavefront to execute |
| sched_done | output | 1 | One-cycle pulse closing an issue pass |

## Verification
The hardest case to reach is a collision between the two passes: an analysis request arriving while an issue pass is still running. To produce it, the bench raises `ana_req` in the very cycle the first index appears, then issues the same schedule again to prove the flags survived. The opposite collision gets the same treatment: an issue request is raised on a mask beat in the middle of an analysis. Analysis beats are also interleaved with idle cycles that carry all-ones garbage. This checks that only qualified beats advance the wavefront count, which no clean stream would reveal.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ANALYSE = 2'd1,
        S_ISSUE   = 2'd2
    } sched_state_e;
endpackage

// File: rtl/wfs_geometry.sv
module wfs_geometry #(
    parameter int LANES  = 8,
    parameter int MAX_WF = 64,
    parameter int LEN_W  = 10,
    parameter int CNT_W  = 7,
    parameter int LANE_W = 3
) (
    input  logic [LEN_W-1:0]  len,
    output logic [CNT_W-1:0]  wf_count,
    output logic [LANE_W-1:0] tail_lanes
);
    localparam int CAP   = MAX_WF * LANES;
    localparam int WIDE  = LEN_W + 2;

    logic [WIDE-1:0] clamped;
    logic [WIDE-1:0] rounded;

    always_comb begin
        if (WIDE'(len) > WIDE'(CAP)) begin
            clamped = WIDE'(CAP);
        end else begin
            clamped = WIDE'(len);
        end
        rounded    = (clamped + WIDE'(LANES - 1)) >> LANE_W;
        wf_count   = rounded[CNT_W-1:0];
        tail_lanes = clamped[LANE_W-1:0];
    end
endmodule

// File: rtl/wfs_lane_filter.sv
module wfs_lane_filter #(
    parameter int LANES  = 8,
    parameter int LANE_W = 3
) (
    input  logic [LANES-1:0]  mask,
    input  logic              is_last,
    input  logic [LANE_W-1:0] tail_lanes,
    output logic              any_active
);
    logic [LANES-1:0] lane_ok;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_ok[g] = !is_last || (tail_lanes == '0) ||
                                (LANE_W'(g) < tail_lanes);
        end
    endgenerate

    assign any_active = |(mask & lane_ok);
endmodule

// File: rtl/wfs_flag_store.sv
module wfs_flag_store #(
    parameter int MAX_WF = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              set_val,
    output logic [MAX_WF-1:0] flags
);
    generate
        for (genvar g = 0; g < MAX_WF; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[g] <= 1'b0;
                end else if (clear) begin
                    flags[g] <= 1'b0;
                end else if (set_en && (set_idx == IDX_W'(g))) begin
                    flags[g] <= set_val;
                end
            end
        end
    endgenerate

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flags == '0)); // R5
endmodule

// File: rtl/wfs_next_pick.sv
module wfs_next_pick #(
    parameter int MAX_WF = 64,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 7
) (
    input  logic [MAX_WF-1:0] flags,
    input  logic [CNT_W-1:0]  cursor,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    logic [MAX_WF-1:0] eligible;

    generate
        for (genvar g = 0; g < MAX_WF; g++) begin : g_elig
            assign eligible[g] = flags[g] && (CNT_W'(g) >= cursor);
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MAX_WF - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wf_skip_sched.sv
module wf_skip_sched #(
    parameter int LANES  = 8,
    parameter int MAX_WF = 64,
    parameter int LEN_W  = $clog2(MAX_WF * LANES + 1),
    parameter int IDX_W  = $clog2(MAX_WF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ana_req,
    input  logic [LEN_W-1:0]  ana_len,
    input  logic              mask_valid,
    input  logic [LANES-1:0]  mask_bits,
    output logic              ana_active,
    input  logic              iss_req,
    output logic              wf_valid,
    output logic [IDX_W-1:0]  wf_idx,
    output logic              sched_done
);
    import wfs_pkg::*;

    localparam int CNT_W  = $clog2(MAX_WF + 1);
    localparam int LANE_W = $clog2(LANES);

    sched_state_e      state_q, state_d;
    logic [CNT_W-1:0]  nwf_q;
    logic [LANE_W-1:0] tail_q;
    logic [CNT_W-1:0]  beat_q;
    logic [CNT_W-1:0]  cursor_q;

    logic [CNT_W-1:0]  geo_count;
    logic [LANE_W-1:0] geo_tail;
    logic [MAX_WF-1:0] flag_vec;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              beat_any;
    logic              beat_is_last;
    logic              accept_ana;
    logic              accept_iss;
    logic              beat_take;

    assign accept_ana   = (state_q == S_IDLE) && ana_req;
    assign accept_iss   = (state_q == S_IDLE) && !ana_req && iss_req;
    assign beat_take    = (state_q == S_ANALYSE) && mask_valid;
    assign beat_is_last = (beat_q == (nwf_q - CNT_W'(1)));

    wfs_geometry #(
        .LANES(LANES), .MAX_WF(MAX_WF), .LEN_W(LEN_W),
        .CNT_W(CNT_W), .LANE_W(LANE_W)
    ) u_geo (
        .len        (ana_len),
        .wf_count   (geo_count),
        .tail_lanes (geo_tail)
    );

    wfs_lane_filter #(.LANES(LANES), .LANE_W(LANE_W)) u_filter (
        .mask       (mask_bits),
        .is_last    (beat_is_last),
        .tail_lanes (tail_q),
        .any_active (beat_any)
    );

    wfs_flag_store #(.MAX_WF(MAX_WF), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept_ana),
        .set_en  (beat_take),
        .set_idx (beat_q[IDX_W-1:0]),
        .set_val (beat_any),
        .flags   (flag_vec)
    );

    wfs_next_pick #(.MAX_WF(MAX_WF), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
        .flags  (flag_vec),
        .cursor (cursor_q),
        .found  (pick_found),
        .idx    (pick_idx)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (ana_req) begin
                    state_d = (geo_count == '0) ? S_IDLE : S_ANALYSE;
                end else if (iss_req) begin
                    state_d = S_ISSUE;
                end
            end
            S_ANALYSE: begin
                if (mask_valid && beat_is_last) begin
                    state_d = S_IDLE;
                end
            end
            S_ISSUE: begin
                if (!pick_found) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            nwf_q    <= '0;
            tail_q   <= '0;
            beat_q   <= '0;
            cursor_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_ana) begin
                nwf_q  <= geo_count;
                tail_q <= geo_tail;
                beat_q <= '0;
            end else if (beat_take) begin
                beat_q <= beat_q + CNT_W'(1);
            end
            if (accept_iss) begin
                cursor_q <= '0;
            end else if ((state_q == S_ISSUE) && pick_found) begin
                cursor_q <= CNT_W'(pick_idx) + CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        ana_active = 1'b0;
        wf_valid   = 1'b0;
        sched_done = 1'b0;
        wf_idx     = pick_idx;
        unique case (state_q)
            S_IDLE:    ;
            S_ANALYSE: ana_active = 1'b1;
            S_ISSUE: begin
                wf_valid   = pick_found;
                sched_done = !pick_found;
            end
            default: ;
        endcase
    end

    AST_IDX_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wf_valid |-> (CNT_W'(wf_idx) < nwf_q)); // R6
    AST_ISSUE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_valid && $past(wf_valid)) |-> (wf_idx > $past(wf_idx))); // R6
    AST_PICK_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wf_valid |-> flag_vec[wf_idx]); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sched_done |=> (!sched_done && !wf_valid)); // R7
    AST_FLAGS_HELD_IN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ISSUE) |=> $stable(flag_vec)); // R10
    AST_ACTIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_active && mask_valid && beat_is_last) |=> !ana_active); // R2
endmodule

// File: tb/wf_skip_sched_test.sv
module wf_skip_sched_test;
    localparam int LANES  = 8;
    localparam int MAX_WF = 64;
    localparam int LEN_W  = 10;
    localparam int IDX_W  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ana_req = 1'b0;
    logic [LEN_W-1:0] ana_len = '0;
    logic             mask_valid = 1'b0;
    logic [LANES-1:0] mask_bits = '0;
    logic             ana_active;
    logic             iss_req = 1'b0;
    logic             wf_valid;
    logic [IDX_W-1:0] wf_idx;
    logic             sched_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] mask_mem [MAX_WF];
    int         cur_len = 0;

    always #5 clk = ~clk;

    wf_skip_sched #(.LANES(LANES), .MAX_WF(MAX_WF)) uut (
        .clk(clk), .rst_n(rst_n), .ana_req(ana_req), .ana_len(ana_len),
        .mask_valid(mask_valid), .mask_bits(mask_bits), .ana_active(ana_active),
        .iss_req(iss_req), .wf_valid(wf_valid), .wf_idx(wf_idx),
        .sched_done(sched_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp_len(input int len);
        return (len > MAX_WF * LANES) ? MAX_WF * LANES : len;
    endfunction

    function automatic bit exp_flag(input int k, input int len);
        int c = clamp_len(len);
        int n = (c + LANES - 1) / LANES;
        int t = c % LANES;
        logic [7:0] m;
        if (k >= n) return 1'b0;
        m = mask_mem[k];
        if (k == n - 1 && t != 0) m = m & 8'((1 << t) - 1);
        return |m;
    endfunction

    task automatic clear_masks();
        for (int i = 0; i < MAX_WF; i++) mask_mem[i] = 8'h00;
    endtask

    // R2 R3 R4 R11: drive an analysis pass; gaps carry garbage that must not count
    task automatic analyse(input int len, input bit poke_iss, input string req);
        int n = (clamp_len(len) + LANES - 1) / LANES;
        @(negedge clk);
        ana_req = 1'b1; ana_len = LEN_W'(len);
        @(negedge clk);
        ana_req = 1'b0;
        cur_len = len;
        check(ana_active == (n > 0), req, ana_active, n > 0);
        for (int k = 0; k < n; k++) begin
            if (k % 3 == 2) begin
                mask_valid = 1'b0; mask_bits = 8'hFF;
                @(negedge clk);
            end
            mask_valid = 1'b1; mask_bits = mask_mem[k];
            iss_req = (poke_iss && k == 0);
            @(negedge clk);
            iss_req = 1'b0;
        end
        mask_valid = 1'b0; mask_bits = '0;
        check(ana_active == 1'b0, req, ana_active, 0);
        check(wf_valid == 1'b0 && sched_done == 1'b0, req, {wf_valid, sched_done}, 0);
    endtask

    // R6 R7 R8: issue and compare against the bench's own flag model
    task automatic run_issue(input bit poke_ana, input string req);
        int exp_idx [MAX_WF];
        int n = 0;
        for (int i = 0; i < MAX_WF; i++) begin
            if (exp_flag(i, cur_len)) begin
                exp_idx[n] = i;
                n++;
            end
        end
        @(negedge clk);
        iss_req = 1'b1;
        @(negedge clk);
        iss_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            check(wf_valid && int'(wf_idx) == exp_idx[k] && !sched_done, req,
                  wf_valid ? int'(wf_idx) : -1, exp_idx[k]);
            ana_req = (poke_ana && k == 0);
            ana_len = LEN_W'(64);
            @(negedge clk);
            ana_req = 1'b0;
        end
        check(sched_done && !wf_valid, req, {wf_valid, sched_done}, 1);
        @(negedge clk);
        check(!sched_done && !wf_valid && !ana_active, req,
              {ana_active, wf_valid, sched_done}, 0);
    endtask

    task automatic t_reset();
        check(!ana_active && !wf_valid && !sched_done, "R1",
              {ana_active, wf_valid, sched_done}, 0);
        cur_len = 0;
        run_issue(1'b0, "R1 R8 empty after reset");
    endtask

    task automatic t_basic();
        clear_masks();
        mask_mem[1] = 8'h01; mask_mem[3] = 8'h80; mask_mem[4] = 8'hFF; mask_mem[7] = 8'h10;
        analyse(64, 1'b0, "R2 full analysis");
        run_issue(1'b0, "R3 R6 R7 sparse schedule");
        run_issue(1'b0, "R9 reuse schedule");
        run_issue(1'b0, "R9 reuse again");
    endtask

    task automatic t_partial();
        clear_masks();
        mask_mem[1] = 8'h02; mask_mem[2] = 8'hE0;
        analyse(21, 1'b0, "R4 partial tail");
        run_issue(1'b0, "R4 R5 tail lanes ignored");
        clear_masks();
        mask_mem[2] = 8'h10;
        analyse(21, 1'b0, "R4 partial tail active");
        run_issue(1'b0, "R4 lane below tail counts");
    endtask

    task automatic t_clear_long();
        for (int i = 0; i < MAX_WF; i++) mask_mem[i] = 8'hFF;
        analyse(512, 1'b0, "R2 all active");
        run_issue(1'b0, "R6 all 64 issued");
        clear_masks();
        mask_mem[0] = 8'h04; mask_mem[63] = 8'h01;
        analyse(512, 1'b0, "R5 reanalysis");
        run_issue(1'b0, "R5 old flags cleared");
    endtask

    task automatic t_all_empty();
        clear_masks();
        analyse(40, 1'b0, "R8 all masked");
        run_issue(1'b0, "R8 done without index");
    endtask

    task automatic t_len_edges();
        clear_masks();
        mask_mem[0] = 8'hFF;
        analyse(0, 1'b0, "R11 zero length");
        run_issue(1'b0, "R11 zero length empty");
        clear_masks();
        mask_mem[63] = 8'h80;
        analyse(1000, 1'b0, "R11 clamped length");
        run_issue(1'b0, "R11 clamp to 64 full");
    endtask

    task automatic t_refusals();
        clear_masks();
        mask_mem[2] = 8'h01; mask_mem[5] = 8'h40; mask_mem[6] = 8'h08;
        analyse(56, 1'b1, "R10 iss during analysis");
        run_issue(1'b1, "R10 ana during issue");
        run_issue(1'b0, "R10 flags kept after refusal");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_partial();
        t_clear_long();
        t_all_empty();
        t_len_edges();
        t_refusals();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule